// File: doc/BRIEF.md
# Packet Radio Transmit Sequencer

This block is an SPI master that runs one complete transmit for a 2.4 GHz packet radio. A one-cycle `start` strobe captures a 32-bit payload. The sequencer then holds chip-enable low and writes a fixed list of commands, one per chip-select-low frame. The first two frames carry the 5-byte link address, one for the transmit address and one for the pipe-0 receive address. The third frame carries the payload. Six register writes then put the radio into transmit mode.

When the list is done, the sequencer raises chip-enable and keeps it high for a minimum number of clock cycles. After that it waits for the active-low interrupt line. When the interrupt arrives, it drops chip-enable and reads the status register. It then writes all ones back to status to clear the event flags and flushes the transmit FIFO. Finally it pulses `done` and reports the two event flags it read: sent-and-acknowledged, or retry limit reached.

The serial clock is the system clock divided by a parameter, and each command frame has a guard time on chip-select at both ends. The link address is a parameter.

Top module: `radio_tx_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `csn` is 1, and `ce`, `sck` and `done` are 0.
- R2: The serial link uses mode 0 and sends the most significant bit first. `sck` is low whenever `csn` is high. `mosi` changes only while `sck` is low, and `miso` is sampled on the rising edge of `sck`. Every command is framed by one high-to-low transition of `csn`.
- R3: The first frame is 0x30 followed by the 5 address bytes, and the second frame is 0x2A followed by the same 5 bytes. The address bytes are sent as `ADDR[7:0]` first and `ADDR[39:32]` last.
- R4: The third frame is 0xA0 followed by the 4 payload bytes, in the order `payload[7:0]` first to `payload[31:24]` last. All 4 bytes go out in a single `csn`-low burst.
- R5: Frames 4 to 9 are two-byte register writes, in this order: 0x21 0x01, 0x22 0x01, 0x24 0x1F, 0x25 0x28, 0x26 0x0F, 0x20 0x0E.
- R6: `ce` is 0 during every frame. `ce` rises only after the last configuration frame, and `csn` stays high for as long as `ce` is high.
- R7: Each high period of `ce` lasts at least `CE_PULSE_CYC` clock cycles, even when `irq_n` is already low when `ce` rises.
- R8: Once the minimum `ce` time has passed and `irq_n` is low (after two synchronizer stages), `ce` falls. Three frames then follow: 0x07 0x00 (status read), 0x27 0xFF (clear flags), and 0xE1 (flush transmit FIFO).
- R9: One clock cycle after the flush frame's trailing guard, `done` is high for exactly one cycle. At that point `tx_ok` takes bit 5 and `tx_fail` takes bit 4 of the second byte returned by the status read. Both hold their values until the next `done`.
- R10: `start` is ignored while a transmit is in progress. The payload is captured on the accepted `start` cycle, so later changes on `payload` have no effect on that transmit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a transmit |
| payload | input | 32 | Payload; byte 0 is bits 7:0 |
| miso | input | 1 | Serial data from the radio |
| irq_n | input | 1 | Active-low interrupt from the radio (asynchronous) |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the radio |
| csn | output | 1 | Active-low command frame select |
| ce | output | 1 | Radio chip-enable |
| done | output | 1 | One-cycle pulse when the transmit sequence ends |
| tx_ok | output | 1 | Sent-and-acknowledged flag from the final status read |
| tx_fail | output | 1 | Retry-limit flag from the final status read |

## Verification
The assertions check the link-level rules on every cycle:
- `sck` is idle whenever `csn` is high.
- `mosi` does not change while `sck` is high.
- No frame starts while `ce` is high.
- Every `ce` high period meets the minimum width, using a run-length counter.
- `done` is a single-cycle pulse.

The bench scenarios cover what the per-cycle checks cannot. A scoreboard compares the byte content and order of all twelve frames. It also checks that the flags reported at `done` match the status byte the radio model returned, and that `start` or `payload` changes during a busy transmit leave the frame stream unchanged.

// File: rtl/radio_tx_pkg.sv
package radio_tx_pkg;

  localparam int NUM_FRAMES  = 12;
  localparam int FR_CFG_LAST = 8;
  localparam int FR_STAT_RD  = 9;
  localparam int FR_FINAL    = NUM_FRAMES - 1;

  localparam logic [7:0] OP_WRITE_REG = 8'h20;
  localparam logic [7:0] OP_LOAD_PLD  = 8'hA0;
  localparam logic [7:0] OP_FLUSH_TX  = 8'hE1;
  localparam logic [7:0] RG_CFG       = 8'h00;
  localparam logic [7:0] RG_AUTOACK   = 8'h01;
  localparam logic [7:0] RG_PIPES     = 8'h02;
  localparam logic [7:0] RG_RETRY     = 8'h04;
  localparam logic [7:0] RG_CHAN      = 8'h05;
  localparam logic [7:0] RG_RFSET     = 8'h06;
  localparam logic [7:0] RG_STAT      = 8'h07;
  localparam logic [7:0] RG_PIPE0_ADR = 8'h0A;
  localparam logic [7:0] RG_DEST_ADR  = 8'h10;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_BYTE,
    ST_TRAIL,
    ST_GAP,
    ST_CE_HOLD,
    ST_WAIT_IRQ
  } seq_state_t;

  // Number of bytes in each command frame of the script.
  function automatic logic [2:0] frame_len(input logic [3:0] fr);
    case (fr)
      4'd0, 4'd1: frame_len = 3'd6;
      4'd2:       frame_len = 3'd5;
      4'd11:      frame_len = 3'd1;
      default:    frame_len = 3'd2;
    endcase
  endfunction

  // Byte at position pos of frame fr; position 0 is the command byte.
  function automatic logic [7:0] frame_byte(input logic [3:0] fr,
                                            input logic [2:0] pos,
                                            input logic [31:0] pld,
                                            input logic [39:0] adr);
    int k;
    logic [7:0] a_b, p_b, cmd, dat;
    k   = (pos == 3'd0) ? 0 : int'(pos) - 1;
    a_b = 8'(adr >> (8 * k));
    p_b = 8'(pld >> (8 * k));
    case (fr)
      4'd0:    begin cmd = OP_WRITE_REG | RG_DEST_ADR;  dat = a_b;   end
      4'd1:    begin cmd = OP_WRITE_REG | RG_PIPE0_ADR; dat = a_b;   end
      4'd2:    begin cmd = OP_LOAD_PLD;                 dat = p_b;   end
      4'd3:    begin cmd = OP_WRITE_REG | RG_AUTOACK;   dat = 8'h01; end
      4'd4:    begin cmd = OP_WRITE_REG | RG_PIPES;     dat = 8'h01; end
      4'd5:    begin cmd = OP_WRITE_REG | RG_RETRY;     dat = 8'h1F; end
      4'd6:    begin cmd = OP_WRITE_REG | RG_CHAN;      dat = 8'd40; end
      4'd7:    begin cmd = OP_WRITE_REG | RG_RFSET;     dat = 8'h0F; end
      4'd8:    begin cmd = OP_WRITE_REG | RG_CFG;       dat = 8'h0E; end
      4'd9:    begin cmd = RG_STAT;                     dat = 8'h00; end
      4'd10:   begin cmd = OP_WRITE_REG | RG_STAT;      dat = 8'hFF; end
      default: begin cmd = OP_FLUSH_TX;                 dat = 8'h00; end
    endcase
    frame_byte = (pos == 3'd0) ? cmd : dat;
  endfunction

endpackage

// File: rtl/radio_sync2.sv
module radio_sync2 #(
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RESET_VAL;
      q    <= RESET_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int HALF_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(HALF_CYC - 1);

  logic          busy;
  logic [CW-1:0] div_cnt;
  logic [2:0]    bit_cnt;
  logic [7:0]    tx_sh;
  logic [7:0]    rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      rx_byte <= '0;
      sck     <= 1'b0;
      mosi    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          tx_sh   <= tx_byte;
          mosi    <= tx_byte[7];
          div_cnt <= '0;
          bit_cnt <= '0;
          sck     <= 1'b0;
        end
      end else if (div_cnt != DIV_LAST) begin
        div_cnt <= div_cnt + 1'b1;
      end else begin
        div_cnt <= '0;
        if (!sck) begin
          sck   <= 1'b1;
          rx_sh <= (rx_sh << 1) | 8'(miso);
        end else begin
          sck <= 1'b0;
          if (bit_cnt == 3'd7) begin
            busy    <= 1'b0;
            done    <= 1'b1;
            rx_byte <= rx_sh;
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
            tx_sh   <= tx_sh << 1;
            mosi    <= tx_sh[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/radio_tx_seq.sv
module radio_tx_seq
  import radio_tx_pkg::*;
#(
  parameter logic [39:0] ADDR         = 40'hC3_5A_19_E7_42,
  parameter int          SCK_HALF     = 4,
  parameter int          CE_PULSE_CYC = 600,
  parameter int          CSN_GUARD    = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] payload,
  input  logic        miso,
  input  logic        irq_n,
  output logic        sck,
  output logic        mosi,
  output logic        csn,
  output logic        ce,
  output logic        done,
  output logic        tx_ok,
  output logic        tx_fail
);
  localparam int TLIM = (CE_PULSE_CYC > CSN_GUARD) ? CE_PULSE_CYC : CSN_GUARD;
  localparam int TW   = $clog2(TLIM + 1);
  localparam logic [TW-1:0] GUARD_LAST = TW'(CSN_GUARD - 1);
  localparam logic [TW-1:0] PULSE_LAST = TW'(CE_PULSE_CYC - 1);

  seq_state_t  st;
  logic [3:0]  fr;
  logic [2:0]  bp;
  logic [TW-1:0] tmr;
  logic [31:0] pay_q;
  logic        eng_start;
  logic [7:0]  eng_byte;
  logic        eng_done;
  logic [7:0]  eng_rx;
  logic        irq_s;
  logic        ok_q, fail_q;

  radio_sync2 #(.RESET_VAL(1'b1)) u_irq_sync (
    .clk (clk),
    .rst (rst),
    .d   (irq_n),
    .q   (irq_s)
  );

  spi_byte_engine #(.HALF_CYC(SCK_HALF)) u_engine (
    .clk     (clk),
    .rst     (rst),
    .start   (eng_start),
    .tx_byte (eng_byte),
    .miso    (miso),
    .sck     (sck),
    .mosi    (mosi),
    .done    (eng_done),
    .rx_byte (eng_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      fr        <= '0;
      bp        <= '0;
      tmr       <= '0;
      pay_q     <= '0;
      eng_start <= 1'b0;
      eng_byte  <= '0;
      csn       <= 1'b1;
      ce        <= 1'b0;
      done      <= 1'b0;
      ok_q      <= 1'b0;
      fail_q    <= 1'b0;
      tx_ok     <= 1'b0;
      tx_fail   <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      done      <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            pay_q <= payload;
            fr    <= '0;
            bp    <= '0;
            tmr   <= '0;
            csn   <= 1'b0;
            st    <= ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tmr == GUARD_LAST) begin
            tmr       <= '0;
            eng_start <= 1'b1;
            eng_byte  <= frame_byte(fr, 3'd0, pay_q, ADDR);
            st        <= ST_BYTE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_BYTE: begin
          if (eng_done) begin
            if (fr == 4'(FR_STAT_RD) && bp == 3'd1) begin
              {ok_q, fail_q} <= 2'(eng_rx >> 4);
            end
            if (bp == frame_len(fr) - 3'd1) begin
              tmr <= '0;
              st  <= ST_TRAIL;
            end else begin
              bp        <= bp + 3'd1;
              eng_start <= 1'b1;
              eng_byte  <= frame_byte(fr, bp + 3'd1, pay_q, ADDR);
            end
          end
        end
        ST_TRAIL: begin
          if (tmr == GUARD_LAST) begin
            tmr <= '0;
            csn <= 1'b1;
            st  <= ST_GAP;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_GAP: begin
          if (tmr == GUARD_LAST) begin
            tmr <= '0;
            if (fr == 4'(FR_CFG_LAST)) begin
              ce <= 1'b1;
              st <= ST_CE_HOLD;
            end else if (fr == 4'(FR_FINAL)) begin
              done    <= 1'b1;
              tx_ok   <= ok_q;
              tx_fail <= fail_q;
              st      <= ST_IDLE;
            end else begin
              fr  <= fr + 4'd1;
              bp  <= '0;
              csn <= 1'b0;
              st  <= ST_LEAD;
            end
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_CE_HOLD: begin
          if (tmr == PULSE_LAST) begin
            tmr <= '0;
            st  <= ST_WAIT_IRQ;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_WAIT_IRQ: begin
          if (!irq_s) begin
            ce  <= 1'b0;
            fr  <= fr + 4'd1;
            bp  <= '0;
            tmr <= '0;
            csn <= 1'b0;
            st  <= ST_LEAD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/radio_tx_seq_chk.sv
module radio_tx_seq_chk #(
  parameter int CE_PULSE_CYC = 600
) (
  input logic clk,
  input logic rst,
  input logic sck,
  input logic mosi,
  input logic csn,
  input logic ce,
  input logic done
);
  int ce_run;

  always_ff @(posedge clk) begin
    if (rst)     ce_run <= 0;
    else if (ce) ce_run <= ce_run + 1;
    else         ce_run <= 0;
  end

  AST_SCK_IDLE_NO_FRAME: assert property (@(posedge clk) disable iff (rst)
    csn |-> !sck);  // R2
  AST_MOSI_HELD_SCK_HIGH: assert property (@(posedge clk) disable iff (rst)
    (sck && $past(sck)) |-> $stable(mosi));  // R2
  AST_NO_FRAME_WITH_CE: assert property (@(posedge clk) disable iff (rst)
    ce |-> csn);  // R6
  AST_CE_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(ce) |-> (ce_run >= CE_PULSE_CYC));  // R7
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R9
endmodule

bind radio_tx_seq radio_tx_seq_chk #(.CE_PULSE_CYC(CE_PULSE_CYC)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .sck  (sck),
  .mosi (mosi),
  .csn  (csn),
  .ce   (ce),
  .done (done)
);

// File: tb/radio_tx_seq_tb.sv
module radio_tx_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [39:0] T_ADDR = 40'h9F_27_6B_D0_15;
  localparam int T_PULSE = 40;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [31:0] payload = '0;
  logic miso = 1'b0, irq_n;
  logic sck, mosi, csn, ce, done, tx_ok, tx_fail;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  radio_tx_seq #(.ADDR(T_ADDR), .SCK_HALF(2), .CE_PULSE_CYC(T_PULSE), .CSN_GUARD(2)) u_dut (
    .clk(clk), .rst(rst), .start(start), .payload(payload), .miso(miso), .irq_n(irq_n),
    .sck(sck), .mosi(mosi), .csn(csn), .ce(ce), .done(done), .tx_ok(tx_ok), .tx_fail(tx_fail)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---- radio model: status register, interrupt, serial slave ----
  logic [7:0] st_reg = 8'h0E;
  assign irq_n = ~(st_reg[5] | st_reg[4]);

  logic [47:0] fr_bytes;
  int nbytes = 0, nbits = 0, frames_seen = 0;
  logic [7:0] sh_in, sh_out;

  // ---- scoreboard ----
  logic [51:0] exp_q[$];

  task automatic push_frame(input int len, input logic [47:0] b);
    exp_q.push_back({4'(len), b});
  endtask

  task automatic push_expected(input logic [31:0] p);
    logic [47:0] ab;
    for (int i = 0; i < 5; i++) ab[8*i +: 8] = T_ADDR[8*i +: 8];
    push_frame(6, {ab[39:0], 8'h30});
    push_frame(6, {ab[39:0], 8'h2A});
    push_frame(5, {8'h00, p, 8'hA0});
    push_frame(2, {32'h0, 8'h01, 8'h21});
    push_frame(2, {32'h0, 8'h01, 8'h22});
    push_frame(2, {32'h0, 8'h1F, 8'h24});
    push_frame(2, {32'h0, 8'h28, 8'h25});
    push_frame(2, {32'h0, 8'h0F, 8'h26});
    push_frame(2, {32'h0, 8'h0E, 8'h20});
    push_frame(2, {32'h0, 8'h00, 8'h07});
    push_frame(2, {32'h0, 8'hFF, 8'h27});
    push_frame(1, {40'h0, 8'hE1});
  endtask

  function automatic string frame_req(input int idx);
    if (idx < 2) return "R3";
    if (idx == 2) return "R4";
    if (idx < 9) return "R5";
    return "R8";
  endfunction

  always @(negedge csn) begin
    nbytes = 0; nbits = 0; fr_bytes = '0;
    sh_out = st_reg;
    miso = sh_out[7];
    if (!rst) chk(ce == 1'b0, "R6", "ce low at frame start", 64'(ce), 64'd0);
  end

  always @(posedge sck) if (!csn) begin
    sh_in = {sh_in[6:0], mosi};
    nbits++;
    if (nbits == 8) begin
      fr_bytes[8*nbytes +: 8] = sh_in;
      nbytes++;
      nbits = 0;
    end
  end

  always @(negedge sck) if (!csn) begin
    if (nbits == 0)
      sh_out = (nbytes == 1 && fr_bytes[7:0] == 8'h07) ? st_reg : 8'h00;
    else
      sh_out = sh_out << 1;
    miso = sh_out[7];
  end

  // monitor: compare each completed frame with the queue head
  always @(posedge csn) if (!rst) begin
    logic [51:0] e;
    int idx;
    idx = frames_seen % 12;
    frames_seen++;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R10", "unexpected frame", {12'h0, 4'(nbytes), fr_bytes}, 64'd0);
    end else begin
      e = exp_q.pop_front();
      chk({4'(nbytes), fr_bytes} == e, frame_req(idx), "frame bytes (R2 mode 0 MSB first)",
          {12'h0, 4'(nbytes), fr_bytes}, {12'h0, e});
    end
    if (nbytes == 2 && fr_bytes[7:0] == 8'h27) st_reg[6:4] = st_reg[6:4] & ~fr_bytes[14:12];
  end

  // ce width monitor
  int ce_cnt = 0;
  always @(negedge clk) begin
    if (ce) ce_cnt++;
    else if (ce_cnt > 0) begin
      chk(ce_cnt >= T_PULSE, "R7", "ce high width", 64'(ce_cnt), 64'(T_PULSE));
      ce_cnt = 0;
    end
  end

  task automatic run_txn(input logic [31:0] p, input int flag_bit, input int irq_delay,
                         input bit disturb);
    push_expected(p);
    @(negedge clk); payload = p; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (disturb) begin
      payload = ~p;
      repeat (50) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    @(posedge ce);
    repeat (irq_delay) @(posedge clk);
    st_reg[flag_bit] = 1'b1;
    @(negedge clk);
    while (!done) @(negedge clk);
    chk(tx_ok == (flag_bit == 5), "R9", "tx_ok at done", 64'(tx_ok), 64'(flag_bit == 5));
    chk(tx_fail == (flag_bit == 4), "R9", "tx_fail at done", 64'(tx_fail), 64'(flag_bit == 4));
    chk(exp_q.size() == 0, "R8", "all frames seen by done", 64'(exp_q.size()), 64'd0);
    chk(irq_n == 1'b1, "R8", "flags cleared by status write", 64'(irq_n), 64'd1);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", 64'(done), 64'd0);
    repeat (100) @(negedge clk);
    chk(tx_ok == (flag_bit == 5), "R9", "tx_ok held", 64'(tx_ok), 64'(flag_bit == 5));
    chk(csn == 1'b1 && ce == 1'b0, "R10", "idle after done, no extra work",
        64'({csn, ce}), 64'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(csn == 1'b1, "R1", "csn in reset", 64'(csn), 64'd1);
    chk(ce == 1'b0, "R1", "ce in reset", 64'(ce), 64'd0);
    chk(sck == 1'b0, "R1", "sck in reset", 64'(sck), 64'd0);
    chk(done == 1'b0, "R1", "done in reset", 64'(done), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(csn == 1'b1 && ce == 1'b0, "R1", "idle after reset", 64'({csn, ce}), 64'b10);
    run_txn(32'h1234_5678, 5, 20, 1'b0);   // acknowledged
    run_txn(32'hDEAD_BEEF, 4, 60, 1'b0);   // retry limit
    run_txn(32'h00FF_A55A, 5, 0, 1'b0);    // interrupt early: R7 minimum still met
    run_txn(32'hC001_0F0F, 4, 5, 1'b1);    // start and payload disturbed while busy (R10)
    chk(frames_seen == 48, "R10", "total frames", 64'(frames_seen), 64'd48);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule